// File: doc/BRIEF.md
# Banked Dual Data Pointer

This block keeps two independent 16-bit data pointers for an 8-bit microcontroller core and shows only one of them to the rest of the core at a time. A single select bit, held in bit 0 of an auxiliary control register, decides which pointer is visible. Every pointer access goes to the visible pointer: byte reads and writes through the special-function-register port, a 16-bit immediate load, a post-increment strobe, and the external-memory address output. The hidden pointer keeps its value.

Block-move software keeps the source address in one pointer and the destination in the other, and switches between them by incrementing the auxiliary register. All bits of that register except bit 0 are hardwired to zero, so an increment only toggles the select bit. The copy loop therefore behaves the same whichever pointer is selected when it starts.

Top module: `dptr_bank`

## Requirements
- R1: After reset both pointers hold 0000h, the select bit is 0, `xmem_addr` is 0000h, and a read of the auxiliary register returns 00h.
- R2: The auxiliary register sits at SFR address A2h. Its bit 0 is the select bit (0 selects pointer 0, 1 selects pointer 1). A write sets the select bit to `sfr_wdata[0]`. Bits 7..1 always read 0 and ignore writes.
- R3: A pulse on `aux_inc` inverts the select bit. If an SFR write to A2h happens in the same cycle, the written value wins.
- R4: SFR address 83h reaches the high byte and 84h the low byte of the selected pointer, for both read and write. The other pointer is not touched.
- R5: `ptr_load` writes `ptr_load_val` into all 16 bits of the selected pointer.
- R6: `ptr_inc` adds 1 to the selected pointer as a full 16-bit add. The carry passes from the low byte into the high byte, and FFFFh wraps to 0000h.
- R7: On the selected pointer, an SFR byte write beats `ptr_load`, and `ptr_load` beats `ptr_inc`. The losing operations in that cycle are dropped.
- R8: The unselected pointer holds its value whatever the inputs do. `xmem_addr` always equals the selected pointer.
- R9: A change of the select bit takes effect from the next cycle. A load, increment or byte write in the same cycle as the change goes to the pointer that was selected before the change.
- R10: An SFR read at any address other than 83h, 84h or A2h returns 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sfr_addr | input | 8 | SFR address for read and write |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data (combinational) |
| aux_inc | input | 1 | Increment of the auxiliary register (toggles the select bit) |
| ptr_load | input | 1 | Load the selected pointer with an immediate value |
| ptr_load_val | input | 16 | Immediate value for the load |
| ptr_inc | input | 1 | Post-increment of the selected pointer |
| xmem_addr | output | 16 | Selected pointer, used as the external-memory address |

## Verification
The bench goes after the carry from low into high byte and the FFFFh wrap. A design that increments only the low byte would give 0000h instead of 0100h, or would stop at FF00h. It drives a toggle in the same cycle as an increment, where a design that applies the new selection at once would bump the wrong pointer. It also forces byte writes against loads and increments, and writes all ones to the auxiliary register, which exposes a register that keeps its upper bits (later increments would no longer toggle cleanly). A NUL-terminated string copy is run once from each starting select value; the result must match both times and the select bit must end inverted.

// File: rtl/dptr_pkg.sv
package dptr_pkg;

  // One operation per pointer slot per cycle, in priority order.
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_WR_HI = 3'd1,
    OP_WR_LO = 3'd2,
    OP_LOAD  = 3'd3,
    OP_INC   = 3'd4
  } slot_op_e;

  // Byte writes first, then the immediate load, then the increment.
  function automatic slot_op_e pick_op(input logic wr_hi, input logic wr_lo,
                                       input logic ld, input logic inc);
    if (wr_hi)      return OP_WR_HI;
    else if (wr_lo) return OP_WR_LO;
    else if (ld)    return OP_LOAD;
    else if (inc)   return OP_INC;
    else            return OP_HOLD;
  endfunction

endpackage

// File: rtl/dptr_auxreg.sv
module dptr_auxreg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic toggle_i,
  output logic dps_o,
  output logic flip_o
);

  logic dps_q;
  logic dps_d;

  // A direct write wins over the toggle strobe.
  always_comb begin
    if (wr_i)          dps_d = wbit_i;
    else if (toggle_i) dps_d = ~dps_q;
    else               dps_d = dps_q;
  end

  // Event: the select bit changes at the next edge.
  assign flip_o = dps_d ^ dps_q;
  assign dps_o  = dps_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dps_q <= 1'b0;
    else        dps_q <= dps_d;
  end

  // R3: the toggle alone inverts the bit
  p_toggle_flips_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle_i && !wr_i) |=> (dps_q != $past(dps_q)));

  // R3: a write in the same cycle decides the value
  p_write_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (dps_q == $past(wbit_i)));

endmodule

// File: rtl/dptr_slot.sv
module dptr_slot
  import dptr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int PTR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ld_i,
  input  logic [PTR_W-1:0]  ld_val_i,
  input  logic              inc_i,
  output logic [PTR_W-1:0]  ptr_o
);

  localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

  // Full-width add, so the carry runs through both bytes and wraps.
  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] v);
    return v + ONE;
  endfunction

  logic [PTR_W-1:0] ptr_q;
  slot_op_e         op;

  // An unselected slot sees every request as idle.
  assign op = sel_i ? pick_op(wr_hi_i, wr_lo_i, ld_i, inc_i) : OP_HOLD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else begin
      unique case (op)
        OP_WR_HI: ptr_q[PTR_W-1:DATA_W] <= wdata_i;
        OP_WR_LO: ptr_q[DATA_W-1:0]     <= wdata_i;
        OP_LOAD:  ptr_q                 <= ld_val_i;
        OP_INC:   ptr_q                 <= bump(ptr_q);
        default:  ptr_q                 <= ptr_q;
      endcase
    end
  end

  assign ptr_o = ptr_q;

  // R8: a hidden pointer never moves
  p_unsel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> $stable(ptr_q));

  // R7: a low-byte write beats a same-cycle increment
  p_wr_beats_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && wr_lo_i && inc_i) |=>
      (ptr_q[DATA_W-1:0] == $past(wdata_i)) &&
      (ptr_q[PTR_W-1:DATA_W] == $past(ptr_q[PTR_W-1:DATA_W])));

  // R7: a load beats a same-cycle increment
  p_load_beats_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && ld_i && inc_i && !wr_hi_i && !wr_lo_i) |=>
      (ptr_q == $past(ld_val_i)));

endmodule

// File: rtl/dptr_rdmux.sv
module dptr_rdmux #(
  parameter int                DATA_W = 8,
  parameter int                ADDR_W = 8,
  parameter logic [ADDR_W-1:0] A_HI   = 8'h83,
  parameter logic [ADDR_W-1:0] A_LO   = 8'h84,
  parameter logic [ADDR_W-1:0] A_AUX  = 8'hA2,
  localparam int               PTR_W  = 2 * DATA_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              dps_i,
  output logic [DATA_W-1:0] rdata_o
);

  always_comb begin
    if (addr_i == A_HI)       rdata_o = ptr_i[PTR_W-1:DATA_W];
    else if (addr_i == A_LO)  rdata_o = ptr_i[DATA_W-1:0];
    else if (addr_i == A_AUX) rdata_o = {{(DATA_W-1){1'b0}}, dps_i};
    else                      rdata_o = '0;
  end

endmodule

// File: rtl/dptr_bank.sv
module dptr_bank #(
  parameter int                DATA_W = 8,
  parameter int                ADDR_W = 8,
  parameter logic [ADDR_W-1:0] A_HI   = 8'h83,
  parameter logic [ADDR_W-1:0] A_LO   = 8'h84,
  parameter logic [ADDR_W-1:0] A_AUX  = 8'hA2,
  localparam int               PTR_W  = 2 * DATA_W,
  localparam int               NSLOT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [DATA_W-1:0] sfr_rdata,
  input  logic              aux_inc,
  input  logic              ptr_load,
  input  logic [PTR_W-1:0]  ptr_load_val,
  input  logic              ptr_inc,
  output logic [PTR_W-1:0]  xmem_addr
);

  localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

  // Named decode events
  logic wr_hi, wr_lo, wr_aux, ptr_byte_wr;
  logic dps, dps_flip;
  logic [PTR_W-1:0] slot_ptr [NSLOT];

  assign wr_hi       = sfr_wr && (sfr_addr == A_HI);
  assign wr_lo       = sfr_wr && (sfr_addr == A_LO);
  assign wr_aux      = sfr_wr && (sfr_addr == A_AUX);
  assign ptr_byte_wr = wr_hi || wr_lo;

  dptr_auxreg u_aux (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (wr_aux),
    .wbit_i   (sfr_wdata[0]),
    .toggle_i (aux_inc),
    .dps_o    (dps),
    .flip_o   (dps_flip)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic sel;
    assign sel = (dps == g[0]);
    dptr_slot #(.DATA_W(DATA_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_i    (sel),
      .wr_hi_i  (wr_hi),
      .wr_lo_i  (wr_lo),
      .wdata_i  (sfr_wdata),
      .ld_i     (ptr_load),
      .ld_val_i (ptr_load_val),
      .inc_i    (ptr_inc),
      .ptr_o    (slot_ptr[g])
    );
  end

  assign xmem_addr = dps ? slot_ptr[1] : slot_ptr[0];

  dptr_rdmux #(
    .DATA_W (DATA_W), .ADDR_W (ADDR_W),
    .A_HI (A_HI), .A_LO (A_LO), .A_AUX (A_AUX)
  ) u_rd (
    .addr_i  (sfr_addr),
    .ptr_i   (xmem_addr),
    .dps_i   (dps),
    .rdata_o (sfr_rdata)
  );

  // R6: a lone increment steps the visible address by one, with wrap
  p_inc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && !ptr_byte_wr && !ptr_load && !dps_flip) |=>
      (xmem_addr == $past(xmem_addr) + ONE));

  // R2: upper auxiliary bits read as zero
  p_aux_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == A_AUX) |-> (sfr_rdata[DATA_W-1:1] == '0));

  // R10: unmapped addresses read zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr != A_HI && sfr_addr != A_LO && sfr_addr != A_AUX) |->
      (sfr_rdata == '0));

  // R9: after a flip, the visible pointer is the other slot
  p_flip_swaps_view_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dps_flip |=> (dps != $past(dps)));

endmodule

// File: tb/dptr_bank_tb.sv
module dptr_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sfr_addr = 8'h00;
  logic        sfr_wr = 1'b0;
  logic [7:0]  sfr_wdata = 8'h00;
  logic [7:0]  sfr_rdata;
  logic        aux_inc = 1'b0;
  logic        ptr_load = 1'b0;
  logic [15:0] ptr_load_val = 16'h0000;
  logic        ptr_inc = 1'b0;
  logic [15:0] xmem_addr;

  int errors = 0;
  int checks = 0;

  // Bench model
  logic [15:0] m_ptr [2];
  logic        m_dps;
  logic [7:0]  mem [256];

  always #5 clk = ~clk;

  dptr_bank u_dut (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .aux_inc(aux_inc),
    .ptr_load(ptr_load), .ptr_load_val(ptr_load_val), .ptr_inc(ptr_inc),
    .xmem_addr(xmem_addr)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench's own statement of the next-state rules
  function automatic logic [15:0] plus_one(input logic [15:0] v);
    logic [7:0] lo, hi;
    lo = v[7:0] + 8'd1;
    hi = (v[7:0] == 8'hFF) ? v[15:8] + 8'd1 : v[15:8];
    return {hi, lo};
  endfunction

  task automatic model(input logic [7:0] a, input logic w, input logic [7:0] d,
                       input logic ai, input logic ld, input logic [15:0] lv,
                       input logic inc);
    logic s;
    s = m_dps;
    if (w && a == 8'h83)      m_ptr[s][15:8] = d;
    else if (w && a == 8'h84) m_ptr[s][7:0]  = d;
    else if (ld)              m_ptr[s]       = lv;
    else if (inc)             m_ptr[s]       = plus_one(m_ptr[s]);
    if (w && a == 8'hA2) m_dps = d[0];
    else if (ai)         m_dps = ~m_dps;
  endtask

  // Drive one cycle at the falling edge, model it, return at the next falling edge.
  task automatic step(input logic [7:0] a, input logic w, input logic [7:0] d,
                      input logic ai, input logic ld, input logic [15:0] lv,
                      input logic inc);
    sfr_addr = a; sfr_wr = w; sfr_wdata = d; aux_inc = ai;
    ptr_load = ld; ptr_load_val = lv; ptr_inc = inc;
    @(posedge clk);
    model(a, w, d, ai, ld, lv, inc);
    @(negedge clk);
    sfr_wr = 1'b0; aux_inc = 1'b0; ptr_load = 1'b0; ptr_inc = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    sfr_addr = a; sfr_wr = 1'b0;
    #1 v = sfr_rdata;
  endtask

  task automatic check_view(input string req);
    logic [7:0] v;
    chk(req, xmem_addr, m_ptr[m_dps]);
    rd(8'h83, v); chk(req, {8'h00, v}, {8'h00, m_ptr[m_dps][15:8]});
    rd(8'h84, v); chk(req, {8'h00, v}, {8'h00, m_ptr[m_dps][7:0]});
    rd(8'hA2, v); chk(req, {8'h00, v}, {15'h0000, m_dps});
  endtask

  // Block copy of a NUL-terminated string, starting from select value s.
  task automatic block_copy(input logic s);
    logic [7:0] b, v;
    string msg;
    int guard;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    msg = "dual-ptr!";
    for (int i = 0; i < msg.len(); i++) mem[8'h10 + i] = msg[i];
    step(8'hA2, 1'b1, {7'd0, s}, 1'b0, 1'b0, 16'h0, 1'b0);
    step(8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 16'h0010, 1'b0);  // source
    step(8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 16'h0, 1'b0);
    step(8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 16'h0080, 1'b0);  // destination
    guard = 0;
    do begin
      step(8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 16'h0, 1'b0);  // to source
      b = mem[xmem_addr[7:0]];
      step(8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 16'h0, 1'b1);  // inc source, to dest
      mem[xmem_addr[7:0]] = b;
      step(8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0, 1'b1);  // inc dest
      guard++;
    end while (b != 8'h00 && guard < 40);
    for (int i = 0; i <= msg.len(); i++)
      chk("R3 copy data", {8'h00, mem[8'h80 + i]}, {8'h00, mem[8'h10 + i]});
    rd(8'hA2, v);
    chk("R3 copy ends inverted", {8'h00, v}, {15'h0000, ~s});
    chk("R8 copy dest ptr", xmem_addr, 16'h0080 + 16'(msg.len()) + 16'd1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    logic [7:0] a;
    void'($urandom(32'd1234));
    m_ptr[0] = 16'h0; m_ptr[1] = 16'h0; m_dps = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 xmem", xmem_addr, 16'h0000);
    rd(8'hA2, v); chk("R1 aux", {8'h00, v}, 16'h0000);
    rd(8'h83, v); chk("R1 hi", {8'h00, v}, 16'h0000);

    // R2 write all ones: only bit 0 sticks
    step(8'hA2, 1'b1, 8'hFF, 1'b0, 1'b0, 16'h0, 1'b0);
    rd(8'hA2, v); chk("R2 aux upper ignored", {8'h00, v}, 16'h0001);
    // R3 toggle twice then write wins over toggle
    step(8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 16'h0, 1'b0);
    rd(8'hA2, v); chk("R3 toggle", {8'h00, v}, 16'h0000);
    step(8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 16'h0, 1'b0);
    rd(8'hA2, v); chk("R3 toggle again", {8'h00, v}, 16'h0001);
    step(8'hA2, 1'b1, 8'h01, 1'b1, 1'b0, 16'h0, 1'b0);
    rd(8'hA2, v); chk("R3 write beats toggle", {8'h00, v}, 16'h0001);

    // R4 byte writes to pointer 1, pointer 0 untouched
    step(8'h83, 1'b1, 8'hAB, 1'b0, 1'b0, 16'h0, 1'b0);
    step(8'h84, 1'b1, 8'hCD, 1'b0, 1'b0, 16'h0, 1'b0);
    chk("R4 bytes p1", xmem_addr, 16'hABCD);
    step(8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 16'h0, 1'b0);
    chk("R8 p0 untouched", xmem_addr, 16'h0000);

    // R5 load and R6 carry/wrap on pointer 0
    step(8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 16'h00FF, 1'b0);
    chk("R5 load", xmem_addr, 16'h00FF);
    step(8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0, 1'b1);
    chk("R6 carry", xmem_addr, 16'h0100);
    step(8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 16'hFFFF, 1'b0);
    step(8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0, 1'b1);
    chk("R6 wrap", xmem_addr, 16'h0000);

    // R7 priorities
    step(8'h84, 1'b1, 8'h55, 1'b0, 1'b1, 16'h1234, 1'b1);
    chk("R7 byte write beats load and inc", xmem_addr, 16'h0055);
    step(8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 16'h1234, 1'b1);
    chk("R7 load beats inc", xmem_addr, 16'h1234);

    // R9 increment in the flip cycle hits the old pointer
    step(8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 16'h0, 1'b1);
    chk("R9 view after flip", xmem_addr, 16'hABCD);
    step(8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 16'h0, 1'b0);
    chk("R9 old ptr bumped", xmem_addr, 16'h1235);

    // R10 unmapped read
    rd(8'h82, v); chk("R10 unmapped", {8'h00, v}, 16'h0000);
    rd(8'hA3, v); chk("R10 unmapped", {8'h00, v}, 16'h0000);

    // Random mix against the bench model
    for (int n = 0; n < 400; n++) begin
      logic [15:0] lv;
      logic [7:0]  d;
      logic        w, ai, ld, inc;
      case ($urandom % 4)
        0: a = 8'h83;
        1: a = 8'h84;
        2: a = 8'hA2;
        default: a = 8'h82;
      endcase
      w   = ($urandom % 10) < 3;
      d   = 8'($urandom);
      ai  = ($urandom % 4) == 0;
      ld  = ($urandom % 5) == 0;
      inc = ($urandom % 5) < 2;
      lv  = (($urandom % 4) == 0) ? 16'hFFFF : 16'($urandom);
      step(a, w, d, ai, ld, lv, inc);
      check_view("R8 random");
      rd(8'h82, v);
      if (v !== 8'h00) chk("R10 random", {8'h00, v}, 16'h0000);
    end
    // Hidden pointer held through the random run
    step(8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 16'h0, 1'b0);
    check_view("R8 hidden ptr after random");

    block_copy(1'b0);
    block_copy(1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule